// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

The block gathers up to thirty-two interrupt request lines and turns them into two request outputs for a processor: a normal request and a fast request. Software sets up each line through a small word-wide register port. Each line can be enabled or masked, can be active-high or active-low, and can be level-sensitive or edge-sensitive. It can also be steered to either output.

Every input first passes through a synchronizer. For a level line, the status bit follows the line after its polarity is applied. For an edge line, the status bit catches the chosen transition and holds it until software clears it by writing a one to that bit. Controllers can be cascaded: one instance's request output drives a line of another instance.

Top module: `sirq_hub`

## Requirements
- R1: After reset, the enable, polarity, trigger-mode and steering registers read zero. Every line is therefore masked, active-low and level-sensitive, and both request outputs are low. With all inputs low, the raw word reads all ones.
- R2: The enable register (byte offset 0x00), polarity register (0x0C), trigger-mode register (0x10) and steering register (0x14) hold whatever is written to them and read it back. Offsets with no register read zero.
- R3: A line whose mode bit is 0 is level-sensitive. Its raw bit (offset 0x04) is 1 while the line equals its polarity bit (polarity 1 means high is active, 0 means low is active). Writing 1 to the raw bit does not clear it while the line stays active.
- R4: A line whose mode bit is 1 is edge-sensitive. Polarity 1 catches a rising edge and polarity 0 catches a falling edge. The opposite transition sets nothing, and a caught event stays set after the line returns.
- R5: Writing a word to offset 0x04 clears each caught edge event whose bit is 1 in that word. Bits written as 0 leave their events untouched.
- R6: If a new edge event arrives in the same cycle as a clearing write to its bit, the bit stays set.
- R7: The pending word at offset 0x08 reads as the raw word AND the enable register. Writes to offset 0x08 change no register.
- R8: The normal request output is the OR of pending bits whose steering bit is 0. The fast request output is the OR of pending bits whose steering bit is 1.
- R9: A change on an input line reaches the raw bit of a level line after two clock edges. It reaches the caught state of an edge line after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe, sampled on the clock edge |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check the edge latch rules on every cycle: a caught event persists until a clearing write, a clearing write without a new event drops it, and a new event beats a clearing write. They also check that the enable register takes the written word, that writes to the pending offset leave the configuration alone, and that both outputs stay low while nothing is pending. Only the bench scenarios can show polarity selection on real line waveforms, that the opposite edge sets nothing, the synchronizer latency, steering between the two outputs, and that a level bit cannot be cleared while its line is active.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int unsigned REG_DW    = 32;
   localparam int unsigned OFF_ENA   = 0;
   localparam int unsigned OFF_RAW   = 4;
   localparam int unsigned OFF_PEND  = 8;
   localparam int unsigned OFF_SENSE = 12;
   localparam int unsigned OFF_MODE  = 16;
   localparam int unsigned OFF_ROUTE = 20;
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("sirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[0] <= '0;
            else         stg_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sirq_detect.sv
module sirq_detect #(
   parameter int unsigned NSRC = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] sync_i,
   input  logic [NSRC-1:0] sense_i,
   input  logic [NSRC-1:0] mode_i,
   input  logic [NSRC-1:0] ack_i,
   output logic [NSRC-1:0] raw_o
);
   logic [NSRC-1:0] prev_q;
   logic [NSRC-1:0] hit;
   logic [NSRC-1:0] level;
   logic [NSRC-1:0] latch_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= sync_i;
   end

   for (genvar g = 0; g < int'(NSRC); g++) begin : g_src
      logic rise, fall;
      assign rise     = sync_i[g] & ~prev_q[g];
      assign fall     = ~sync_i[g] & prev_q[g];
      assign hit[g]   = sense_i[g] ? rise : fall;
      assign level[g] = ~(sync_i[g] ^ sense_i[g]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        latch_q[g] <= 1'b0;
         else if (mode_i[g]) latch_q[g] <= hit[g] | (latch_q[g] & ~ack_i[g]);
         else                latch_q[g] <= 1'b0;
      end

      assign raw_o[g] = mode_i[g] ? latch_q[g] : level[g];

      // R6: a fresh event outranks a clearing write
      a_r6_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i[g] && hit[g]) |=> latch_q[g]);
      // R5: clearing write without a new event drops the event
      a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i[g] && ack_i[g] && !hit[g]) |=> !latch_q[g]);
      // R4: caught event persists while not cleared
      a_r4_event_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i[g] && mode_i[g] && latch_q[g] && !ack_i[g]) |=> latch_q[g]);
   end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
   import sirq_pkg::*;
#(
   parameter int unsigned NSRC   = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_DW-1:0] wdata_i,
   input  logic [NSRC-1:0]   raw_i,
   output logic [NSRC-1:0]   ena_o,
   output logic [NSRC-1:0]   sense_o,
   output logic [NSRC-1:0]   mode_o,
   output logic [NSRC-1:0]   route_o,
   output logic [NSRC-1:0]   ack_o,
   output logic [NSRC-1:0]   pend_o,
   output logic [REG_DW-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_ENA   = ADDR_W'(OFF_ENA);
   localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFF_RAW);
   localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
   localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFF_SENSE);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
   localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFF_ROUTE);

   logic [NSRC-1:0] ena_q, sense_q, mode_q, route_q;
   logic [NSRC-1:0] wsrc;

   assign wsrc = wdata_i[NSRC-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ena_q   <= '0;
         sense_q <= '0;
         mode_q  <= '0;
         route_q <= '0;
      end else if (wr_en_i) begin
         if (addr_i == A_ENA)   ena_q   <= wsrc;
         if (addr_i == A_SENSE) sense_q <= wsrc;
         if (addr_i == A_MODE)  mode_q  <= wsrc;
         if (addr_i == A_ROUTE) route_q <= wsrc;
      end
   end

   assign ack_o   = (wr_en_i && addr_i == A_RAW) ? wsrc : '0;
   assign pend_o  = raw_i & ena_q;
   assign ena_o   = ena_q;
   assign sense_o = sense_q;
   assign mode_o  = mode_q;
   assign route_o = route_q;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_ENA:   rdata_o = REG_DW'(ena_q);
         A_RAW:   rdata_o = REG_DW'(raw_i);
         A_PEND:  rdata_o = REG_DW'(pend_o);
         A_SENSE: rdata_o = REG_DW'(sense_q);
         A_MODE:  rdata_o = REG_DW'(mode_q);
         A_ROUTE: rdata_o = REG_DW'(route_q);
         default: rdata_o = '0;
      endcase
   end

   // R2: enable register takes the written word
   a_r2_ena_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_ENA) |=> ena_q == $past(wsrc));
   // R7: the pending offset is read-only
   a_r7_pend_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_PEND) |=>
         ($stable(ena_q) && $stable(sense_q) && $stable(mode_q) && $stable(route_q)));
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
   parameter int unsigned NSRC    = 32,
   parameter int unsigned OUT_REG = 0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] pend_i,
   input  logic [NSRC-1:0] route_i,
   output logic            irq_o,
   output logic            fiq_o
);
   if (OUT_REG > 1) begin : g_bad_opt
      $error("sirq_route: OUT_REG must be 0 or 1");
   end

   logic irq_d, fiq_d;
   assign irq_d = |(pend_i & ~route_i);
   assign fiq_d = |(pend_i & route_i);

   if (OUT_REG == 0) begin : g_comb
      assign irq_o = irq_d;
      assign fiq_o = fiq_d;
   end else begin : g_flop
      logic irq_q, fiq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
         end else begin
            irq_q <= irq_d;
            fiq_q <= fiq_d;
         end
      end
      assign irq_o = irq_q;
      assign fiq_o = fiq_q;
   end

   // R8: no request leaves while nothing has been pending
   a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(pend_i) == '0 && pend_i == '0) |-> (!irq_o && !fiq_o));
endmodule

// File: rtl/sirq_hub.sv
module sirq_hub
   import sirq_pkg::*;
#(
   parameter int unsigned NSRC        = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OUT_REG     = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   src_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_DW-1:0] wdata_i,
   output logic [REG_DW-1:0] rdata_o,
   output logic              irq_o,
   output logic              fiq_o
);
   if (NSRC < 1 || NSRC > REG_DW) begin : g_bad_nsrc
      $error("sirq_hub: NSRC must be within 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("sirq_hub: ADDR_W must reach offset 0x14");
   end

   logic [NSRC-1:0] sync, raw, ena, sense, mode, route, ack, pend;

   sirq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i, .rst_ni, .d_i(src_i), .q_o(sync)
   );

   sirq_detect #(.NSRC(NSRC)) i_detect (
      .clk_i, .rst_ni, .sync_i(sync), .sense_i(sense), .mode_i(mode),
      .ack_i(ack), .raw_o(raw)
   );

   sirq_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) i_regs (
      .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .raw_i(raw),
      .ena_o(ena), .sense_o(sense), .mode_o(mode), .route_o(route),
      .ack_o(ack), .pend_o(pend), .rdata_o
   );

   sirq_route #(.NSRC(NSRC), .OUT_REG(OUT_REG)) i_route (
      .clk_i, .rst_ni, .pend_i(pend), .route_i(route), .irq_o, .fiq_o
   );

   // R1: configuration is cleared on the first cycle out of reset
   a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (ena == '0 && sense == '0 && mode == '0 && route == '0));
   // R8: with everything masked both outputs rest low
   a_r8_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ena) == '0 && ena == '0) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/test_sirq_hub.sv
`timescale 1ns/1ps
module test_sirq_hub;
   localparam logic [4:0] A_ENA = 5'h00, A_RAW = 5'h04, A_PEND = 5'h08,
                          A_SENSE = 5'h0C, A_MODE = 5'h10, A_ROUTE = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   sirq_hub i_sirq_hub (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] v);
      wr_en = 1'b1; addr = a; wdata = v;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_ENA, v);   check("R1 enable", v, 32'h0);
      rd(A_SENSE, v); check("R1 polarity", v, 32'h0);
      rd(A_MODE, v);  check("R1 mode", v, 32'h0);
      rd(A_ROUTE, v); check("R1 steering", v, 32'h0);
      rd(A_RAW, v);   check("R1 raw all active-low", v, 32'hFFFF_FFFF);
      check("R1 outputs", {30'h0, irq, fiq}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(A_ENA, 32'hA5A5_0F0F);   rd(A_ENA, v);   check("R2 enable", v, 32'hA5A5_0F0F);
      wr(A_SENSE, 32'h1234_5678); rd(A_SENSE, v); check("R2 polarity", v, 32'h1234_5678);
      wr(A_MODE, 32'hFEDC_BA98);  rd(A_MODE, v);  check("R2 mode", v, 32'hFEDC_BA98);
      wr(A_ROUTE, 32'h8000_0001); rd(A_ROUTE, v); check("R2 steering", v, 32'h8000_0001);
      rd(5'h18, v); check("R2 unmapped", v, 32'h0);
      wr(A_ENA, 0); wr(A_SENSE, 0); wr(A_MODE, 0); wr(A_ROUTE, 0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(A_SENSE, 32'h0000_0008);
      src[3] = 1'b1;
      @(posedge clk); @(negedge clk);
      rd(A_RAW, v); check("R9 one edge not yet visible", v & 32'h8, 32'h0);
      @(posedge clk); @(negedge clk);
      rd(A_RAW, v); check("R9 level visible after two edges", v & 32'h8, 32'h8);
      rd(A_RAW, v); check("R3 low-active idle line", v & 32'h20, 32'h20);
      wr(A_RAW, 32'h8);
      rd(A_RAW, v); check("R3 write-one does not clear level", v & 32'h8, 32'h8);
      src[3] = 1'b0; settle();
      rd(A_RAW, v); check("R3 level follows line", v & 32'h8, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wr(A_SENSE, 32'h0000_0100);
      wr(A_MODE, 32'h0000_0300);
      settle();
      rd(A_RAW, v); check("R4 edge idle", v & 32'h300, 32'h0);
      src[9] = 1'b1; settle();
      rd(A_RAW, v); check("R4 rising ignored on falling line", v & 32'h200, 32'h0);
      src[8] = 1'b1; settle();
      rd(A_RAW, v); check("R4 rising caught", v & 32'h100, 32'h100);
      src[8] = 1'b0; settle();
      rd(A_RAW, v); check("R4 event held after return", v & 32'h100, 32'h100);
      src[9] = 1'b0; settle();
      rd(A_RAW, v); check("R4 falling caught", v & 32'h200, 32'h200);
   endtask

   task automatic t_ack();
      logic [31:0] v;
      wr(A_RAW, 32'h0);
      rd(A_RAW, v); check("R5 write zero keeps events", v & 32'h300, 32'h300);
      wr(A_RAW, 32'h100);
      rd(A_RAW, v); check("R5 selected event cleared", v & 32'h300, 32'h200);
      wr(A_RAW, 32'h200);
      rd(A_RAW, v); check("R5 second event cleared", v & 32'h300, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      src[8] = 1'b1; settle();
      src[8] = 1'b0; settle();
      rd(A_RAW, v); check("R6 event pending before race", v & 32'h100, 32'h100);
      src[8] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr_en = 1'b1; addr = A_RAW; wdata = 32'h100;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      rd(A_RAW, v); check("R6 new edge beats clear", v & 32'h100, 32'h100);
      wr(A_RAW, 32'h100);
      rd(A_RAW, v); check("R6 later clear works", v & 32'h100, 32'h0);
      src[8] = 1'b0;
      wr(A_MODE, 0); wr(A_SENSE, 0); settle();
   endtask

   task automatic t_pend();
      logic [31:0] v, raw;
      wr(A_ENA, 32'h0F0F_00F0);
      rd(A_RAW, raw);
      rd(A_PEND, v); check("R7 pending is raw and enable", v, raw & 32'h0F0F_00F0);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd(A_ENA, v); check("R7 write to pending leaves enable", v, 32'h0F0F_00F0);
      rd(A_MODE, v); check("R7 write to pending leaves mode", v, 32'h0);
      wr(A_ENA, 0);
   endtask

   task automatic t_route();
      wr(A_SENSE, 32'h8);
      src[3] = 1'b1; settle();
      check("R8 masked line quiet", {30'h0, irq, fiq}, 32'h0);
      wr(A_ENA, 32'h8);
      check("R8 steered to normal", {30'h0, irq, fiq}, 32'h2);
      wr(A_ROUTE, 32'h8);
      check("R8 steered to fast", {30'h0, irq, fiq}, 32'h1);
      src[3] = 1'b0; settle();
      check("R8 inactive line quiet", {30'h0, irq, fiq}, 32'h0);
      wr(A_ENA, 32'h0000_0010);
      check("R8 low-active idle line to normal", {30'h0, irq, fiq}, 32'h2);
      wr(A_ENA, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_regmap();
      t_level();
      t_edge();
      t_ack();
      t_collide();
      t_pend();
      t_route();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule